// File: doc/BRIEF.md
# Programmable Serial Sequencer Engine

This block runs a short microprogram from a local instruction store to drive a serial clock pin, a bidirectional data pin and a chip-select pin. The serial protocol is not built into the hardware. The loaded program produces it: opcodes set or invert pin levels, shift a counted number of bits, branch on the sampled input line, or stop. One engine can therefore bit-bang SPI, two-wire or other simple serial buses.

A 32-bit shift context sits behind the pins. It consists of an upper 16-bit address half and a lower 16-bit data half. A start pulse loads the context from a 32-bit input word and sets the program counter. The engine then executes one instruction per cycle, and a shift takes two cycles per bit. It runs until it reaches a stop. At that point it drops busy, pulses done, presents the context as the result word and records the address where it halted. Two mode inputs change the timing of a shift: one samples the input during the idle half of each clock period instead of the active half, and the other delays each new output bit to the active clock transition.

Top module: `ssq_engine`

## Requirements
- R1: After reset, busy and done are 0, the clock pin is 0, the data output is 0 and undriven (data_oe 0), chip-select is 1, the result is 0 and the stop address is 0.
- R2: A start pulse while idle loads bits 31:16 of the start word into the address half and bits 15:0 into the data half. It also loads the program counter with the start address modulo 32 (bit 5 is ignored) and raises busy on the next cycle. A start pulse while busy has no effect on the running program or its result.
- R3: A stop instruction (opcode 7, bits 7:5) ends the run. Busy falls, done is high for exactly one cycle, the result reads {address half, data half}, and the stop address output holds the address of the halting instruction until the next run ends.
- R4: Opcode 0 drives the pins straight from the instruction: bit 0 sets the clock level, bit 1 the data level, bit 2 chip-select and bit 3 the data output enable.
- R5: Opcode 1 inverts each of clock, data and chip-select whose bit (0, 1, 2) is set, and leaves the others unchanged. Bit 3 sets the output enable.
- R6: Opcode 2 shifts N bits MSB-first through one half. Bit 4 = 1 selects the data half and 0 selects the address half. N is held in bits 15:8, and 0 counts as 1. Each bit enters at the LSB from the input pin. Chip-select and output enable take bits 2 and 3. The clock idles at the bit-0 level, pulses to the opposite level once per bit, and ends at the idle level.
- R7: With early sampling off, each shifted-in bit is taken while the clock is at its active (non-idle) level. With early sampling on, it is taken during the preceding idle half.
- R8: With delayed output off, the data pin shows the next bit before the clock leaves idle. With it on, the data pin changes together with the idle-to-active transition.
- R9: Opcode 4 branches when the input pin is 0, opcode 5 when it is 1, and opcode 6 always. The target is in bits 13:8 taken modulo 32. A branch that is not taken continues at the next address.
- R10: A non-branch, non-stop instruction at address 31 ends the run as if it were a stop, and the stop address reads 31.
- R11: Opcode 3 is a no-operation: it leaves the pins and context unchanged and continues at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | 5 | Instruction store write address |
| prog_data | input | 16 | Instruction word to store |
| start | input | 1 | Begin execution (ignored while busy) |
| start_pc | input | 6 | First instruction address, taken modulo 32 |
| start_word | input | 32 | Initial shift context {address half, data half} |
| early_sample | input | 1 | Sample input during the idle clock half |
| late_drive | input | 1 | Change output data with the active clock transition |
| pin_data_in | input | 1 | Sampled serial data line |
| pin_clk | output | 1 | Serial clock pin |
| pin_data_out | output | 1 | Serial data output level |
| pin_data_oe | output | 1 | Serial data output enable |
| pin_cs | output | 1 | Chip-select pin |
| busy | output | 1 | Program executing |
| done | output | 1 | One-cycle pulse when a run ends |
| result | output | 32 | Shift context {address half, data half} |
| stop_addr | output | 6 | Address of the instruction that ended the last run |

## Verification
A wrong program counter shows up at the end of the run: the stop address differs from the expected halt location, or a branch test halts at the other of its two stop slots. A bad shift count, register select or bit order appears in the result word as soon as done pulses. That happens within 2N+2 cycles of the shift being decoded. A sampling or output-timing phase error is visible within one bit period. The tie-back of the input pin to the clock pin then fills the shifted nibble with the wrong constant, and the data level seen just before the first clock transition is the wrong one.

// File: rtl/ssq_pkg.sv
// Shared encodings for the serial sequencer engine.
// The control byte layout is fixed: the packed struct order matches
// instruction bits 7 down to 0, so a cast decodes it directly.
package ssq_pkg;

    localparam int unsigned CTL_BITS = 8;

    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_FLIP  = 3'd1,
        OP_SHIFT = 3'd2,
        OP_RSVD  = 3'd3,
        OP_JZ    = 3'd4,
        OP_JNZ   = 3'd5,
        OP_JMP   = 3'd6,
        OP_HALT  = 3'd7
    } ssq_op_e;

    typedef struct packed {
        ssq_op_e op;        // bits 7:5
        logic    sel_data;  // bit 4
        logic    drive;     // bit 3
        logic    cs_lvl;    // bit 2
        logic    dat_lvl;   // bit 1
        logic    clk_lvl;   // bit 0
    } ssq_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SHIFT = 2'd2
    } ssq_state_e;

endpackage

// File: rtl/ssq_imem.sv
// Instruction store: single write port, asynchronous read port.
// Assumes DEPTH is a power of two so that address arithmetic wraps.
module ssq_imem #(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned INSTR_W = 16,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [INSTR_W-1:0] wdata,
    input  logic [AW-1:0]      raddr,
    output logic [INSTR_W-1:0] rdata
);

    logic [INSTR_W-1:0] mem_q [DEPTH];

    // Store a program word when the write strobe is high.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ssq_decode.sv
// Instruction decoder: splits a word into control fields, the branch
// target (wrapped to the store size), the shift count (0 read as 1)
// and the branch decision for the present input level.
module ssq_decode
    import ssq_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned AW      = 5,
    localparam int unsigned CNT_W  = INSTR_W - CTL_BITS
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               din,
    output ssq_ctl_t           ctl,
    output logic [AW-1:0]      target,
    output logic [CNT_W-1:0]   count,
    output logic               jump
);

    logic [CNT_W-1:0] arg;

    assign ctl    = ssq_ctl_t'(instr[CTL_BITS-1:0]);
    assign arg    = instr[INSTR_W-1:CTL_BITS];
    assign target = arg[AW-1:0];
    assign count  = (arg == '0) ? CNT_W'(1) : arg;

    // Decide whether a branch opcode is taken.
    always_comb begin
        unique case (ctl.op)
            OP_JZ:   jump = ~din;
            OP_JNZ:  jump = din;
            OP_JMP:  jump = 1'b1;
            default: jump = 1'b0;
        endcase
    end

endmodule

// File: rtl/ssq_ctx.sv
// Shift context: two HALF_W registers, upper = address half, lower =
// data half. Loads both halves at once; shifts the selected half left
// by one with the new bit entering at the LSB.
module ssq_ctx #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sel_data,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              msb,
    output logic              next_msb
);

    logic [1:0] top_bits;
    logic [1:0] second_bits;

    for (genvar g = 0; g < 2; g++) begin : g_half
        localparam bit IS_DATA = (g == 0);
        logic [HALF_W-1:0] r_q;

        // Hold, load or shift one half of the context.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (load) begin
                r_q <= load_word[g*HALF_W +: HALF_W];
            end else if (shift && (sel_data == IS_DATA)) begin
                r_q <= {r_q[HALF_W-2:0], bit_in};
            end
        end

        assign word[g*HALF_W +: HALF_W] = r_q;
        assign top_bits[g]              = r_q[HALF_W-1];
        assign second_bits[g]           = r_q[HALF_W-2];
    end

    assign msb      = sel_data ? top_bits[0]    : top_bits[1];
    assign next_msb = sel_data ? second_bits[0] : second_bits[1];

endmodule

// File: rtl/ssq_pins.sv
// Pin drive registers for clock, data out, data enable and chip-select.
// A load request wins over an inversion request on the same pin.
// Reset leaves chip-select deasserted high and the data line undriven.
module ssq_pins (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_clk,
    input  logic       clk_val,
    input  logic       ld_dat,
    input  logic       dat_val,
    input  logic       ld_cs,
    input  logic       cs_val,
    input  logic       ld_oe,
    input  logic       oe_val,
    input  logic [2:0] flip,
    output logic       pin_clk,
    output logic       pin_dat,
    output logic       pin_cs,
    output logic       pin_oe
);

    // Update the clock pin level.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_clk <= 1'b0;
        else if (ld_clk)  pin_clk <= clk_val;
        else if (flip[0]) pin_clk <= ~pin_clk;
    end

    // Update the data output level.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_dat <= 1'b0;
        else if (ld_dat)  pin_dat <= dat_val;
        else if (flip[1]) pin_dat <= ~pin_dat;
    end

    // Update the chip-select level.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_cs <= 1'b1;
        else if (ld_cs)   pin_cs <= cs_val;
        else if (flip[2]) pin_cs <= ~pin_cs;
    end

    // Update the data output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     pin_oe <= 1'b0;
        else if (ld_oe) pin_oe <= oe_val;
    end

endmodule

// File: rtl/ssq_engine.sv
// Serial sequencer engine top. Fetches from the instruction store at
// the program counter and executes one instruction per cycle; a shift
// spends two cycles per bit (idle half, active half). Ends on a stop
// opcode or on falling off the last address. Assumes the mode inputs
// are stable while busy and that DEPTH is a power of two.
module ssq_engine
    import ssq_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned HALF_W  = 16,
    parameter int unsigned PC_W    = 6,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CNT_W  = INSTR_W - CTL_BITS,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [AW-1:0]      prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               start,
    input  logic [PC_W-1:0]    start_pc,
    input  logic [WORD_W-1:0]  start_word,
    input  logic               early_sample,
    input  logic               late_drive,
    input  logic               pin_data_in,
    output logic               pin_clk,
    output logic               pin_data_out,
    output logic               pin_data_oe,
    output logic               pin_cs,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  result,
    output logic [PC_W-1:0]    stop_addr
);

    ssq_state_e         state_q, nxt_state;
    logic [AW-1:0]      pc_q, nxt_pc;
    logic               phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               idle_q;
    logic               sel_q;
    logic               early_q;
    logic               done_q;
    logic [PC_W-1:0]    stop_q;

    logic [INSTR_W-1:0] instr;
    ssq_ctl_t           ctl;
    logic [AW-1:0]      target;
    logic [CNT_W-1:0]   count;
    logic               jump;

    logic               ctx_load, ctx_shift, ctx_sel, bit_in;
    logic               ctx_msb, ctx_next_msb;
    logic               cnt_load, cnt_dec, step, finish;
    logic               ld_clk, clk_val, ld_dat, dat_val;
    logic               ld_cs, cs_val, ld_oe, oe_val;
    logic [2:0]         flip;

    ssq_imem #(.DEPTH(DEPTH), .INSTR_W(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (pc_q),
        .rdata (instr)
    );

    ssq_decode #(.INSTR_W(INSTR_W), .AW(AW)) u_decode (
        .instr  (instr),
        .din    (pin_data_in),
        .ctl    (ctl),
        .target (target),
        .count  (count),
        .jump   (jump)
    );

    assign ctx_sel = (state_q == ST_RUN) ? ctl.sel_data : sel_q;
    assign bit_in  = early_sample ? early_q : pin_data_in;

    ssq_ctx #(.HALF_W(HALF_W)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctx_load),
        .load_word (start_word),
        .shift     (ctx_shift),
        .sel_data  (ctx_sel),
        .bit_in    (bit_in),
        .word      (result),
        .msb       (ctx_msb),
        .next_msb  (ctx_next_msb)
    );

    ssq_pins u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_clk  (ld_clk),
        .clk_val (clk_val),
        .ld_dat  (ld_dat),
        .dat_val (dat_val),
        .ld_cs   (ld_cs),
        .cs_val  (cs_val),
        .ld_oe   (ld_oe),
        .oe_val  (oe_val),
        .flip    (flip),
        .pin_clk (pin_clk),
        .pin_dat (pin_data_out),
        .pin_cs  (pin_cs),
        .pin_oe  (pin_data_oe)
    );

    // Sequencer control: choose pin, context and program-counter actions.
    always_comb begin
        nxt_state = state_q;
        nxt_pc    = pc_q;
        ctx_load  = 1'b0;
        ctx_shift = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        step      = 1'b0;
        finish    = 1'b0;
        ld_clk    = 1'b0;
        clk_val   = 1'b0;
        ld_dat    = 1'b0;
        dat_val   = 1'b0;
        ld_cs     = 1'b0;
        cs_val    = 1'b0;
        ld_oe     = 1'b0;
        oe_val    = 1'b0;
        flip      = 3'b000;

        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctx_load  = 1'b1;
                    nxt_pc    = AW'(start_pc);
                    nxt_state = ST_RUN;
                end
            end
            ST_RUN: begin
                unique case (ctl.op)
                    OP_SET: begin
                        ld_clk = 1'b1; clk_val = ctl.clk_lvl;
                        ld_dat = 1'b1; dat_val = ctl.dat_lvl;
                        ld_cs  = 1'b1; cs_val  = ctl.cs_lvl;
                        ld_oe  = 1'b1; oe_val  = ctl.drive;
                        step   = 1'b1;
                    end
                    OP_FLIP: begin
                        flip  = {ctl.cs_lvl, ctl.dat_lvl, ctl.clk_lvl};
                        ld_oe = 1'b1; oe_val = ctl.drive;
                        step  = 1'b1;
                    end
                    OP_SHIFT: begin
                        ld_clk    = 1'b1; clk_val = ctl.clk_lvl;
                        ld_cs     = 1'b1; cs_val  = ctl.cs_lvl;
                        ld_oe     = 1'b1; oe_val  = ctl.drive;
                        ld_dat    = ~late_drive;
                        dat_val   = ctx_msb;
                        cnt_load  = 1'b1;
                        nxt_state = ST_SHIFT;
                    end
                    OP_JZ, OP_JNZ, OP_JMP: begin
                        if (jump) nxt_pc = target;
                        else      step   = 1'b1;
                    end
                    OP_HALT: begin
                        finish = 1'b1;
                    end
                    default: begin
                        step = 1'b1;
                    end
                endcase
            end
            ST_SHIFT: begin
                if (!phase_q) begin
                    ld_clk  = 1'b1; clk_val = ~idle_q;
                    ld_dat  = late_drive;
                    dat_val = ctx_msb;
                end else begin
                    ld_clk    = 1'b1; clk_val = idle_q;
                    ctx_shift = 1'b1;
                    ld_dat    = ~late_drive;
                    dat_val   = ctx_next_msb;
                    cnt_dec   = 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        step      = 1'b1;
                        nxt_state = ST_RUN;
                    end
                end
            end
            default: begin
                nxt_state = ST_IDLE;
            end
        endcase

        if (step) begin
            if (pc_q == AW'(DEPTH - 1)) finish = 1'b1;
            else                        nxt_pc = pc_q + AW'(1);
        end
        if (finish) begin
            nxt_state = ST_IDLE;
        end
    end

    // Sequencer state, program counter and run-end reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            done_q  <= 1'b0;
            stop_q  <= '0;
        end else begin
            state_q <= nxt_state;
            pc_q    <= nxt_pc;
            done_q  <= finish;
            if (finish) stop_q <= PC_W'(pc_q);
        end
    end

    // Shift bookkeeping: bit count, half select, idle level and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idle_q  <= 1'b0;
            sel_q   <= 1'b0;
            phase_q <= 1'b0;
            early_q <= 1'b0;
        end else begin
            if (cnt_load) begin
                cnt_q  <= count;
                idle_q <= ctl.clk_lvl;
                sel_q  <= ctl.sel_data;
            end else if (cnt_dec) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            phase_q <= (state_q == ST_SHIFT) ? ~phase_q : 1'b0;
            if (state_q == ST_SHIFT && !phase_q) early_q <= pin_data_in;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign stop_addr = stop_q;

endmodule

// File: rtl/ssq_engine_chk.sv
// Port-level property checker for the serial sequencer engine.
module ssq_engine_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] start_word,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic [PC_W-1:0]   stop_addr,
    input logic              pin_clk,
    input logic              pin_data_out,
    input logic              pin_data_oe,
    input logic              pin_cs
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

    AST_START_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (result == $past(start_word))); // R2

    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(stop_addr))); // R3

    AST_IDLE_HOLDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({pin_clk, pin_data_out, pin_data_oe, pin_cs})); // R4

endmodule

bind ssq_engine ssq_engine_chk #(.WORD_W(WORD_W), .PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_word   (start_word),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .stop_addr    (stop_addr),
    .pin_clk      (pin_clk),
    .pin_data_out (pin_data_out),
    .pin_data_oe  (pin_data_oe),
    .pin_cs       (pin_cs)
);

// File: tb/ssq_engine_tb.sv
// Scoreboard bench: the run task queues the expected {stop, result},
// and a monitor pops and compares on every done pulse.
module ssq_engine_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic        start = 1'b0;
    logic [5:0]  start_pc = '0;
    logic [31:0] start_word = '0;
    logic        early_sample = 1'b0;
    logic        late_drive = 1'b0;
    logic        pin_data_in;
    logic        pin_clk, pin_data_out, pin_data_oe, pin_cs;
    logic        busy, done;
    logic [31:0] result;
    logic [5:0]  stop_addr;

    logic [1:0]  din_mode = 2'd2;   // 0 loopback, 1 tie to clock pin, 2 constant
    logic        din_const = 1'b0;

    assign pin_data_in = (din_mode == 2'd0) ? pin_data_out :
                         (din_mode == 2'd1) ? pin_clk : din_const;

    int n_vec = 0;
    int n_bad = 0;
    int pops  = 0;
    logic [37:0] exp_q [$];

    logic armed = 1'b0;
    logic cap_dout = 1'b0;
    logic prev_clk = 1'b0;
    logic prev_dout = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssq_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_we      (prog_we),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .start        (start),
        .start_pc     (start_pc),
        .start_word   (start_word),
        .early_sample (early_sample),
        .late_drive   (late_drive),
        .pin_data_in  (pin_data_in),
        .pin_clk      (pin_clk),
        .pin_data_out (pin_data_out),
        .pin_data_oe  (pin_data_oe),
        .pin_cs       (pin_cs),
        .busy         (busy),
        .done         (done),
        .result       (result),
        .stop_addr    (stop_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int arg, input bit sel,
                                       input bit drv, input bit cs, input bit dat, input bit ck);
        logic [7:0] a;
        logic [2:0] o;
        a = arg[7:0];
        o = op[2:0];
        return {a, o, sel, drv, cs, dat, ck};
    endfunction

    function automatic logic [15:0] prog_word(input int a);
        case (a)
            0:  return mk(0, 0, 0, 1, 0, 1, 0);
            1:  return mk(7, 0, 0, 0, 0, 0, 0);
            2:  return mk(0, 0, 0, 1, 0, 0, 0);
            3:  return mk(1, 0, 0, 0, 1, 0, 1);
            5:  return mk(2, 4, 1, 1, 0, 0, 0);
            7:  return mk(2, 8, 0, 1, 0, 0, 0);
            9:  return mk(2, 0, 1, 1, 0, 0, 0);
            11: return mk(2, 4, 1, 0, 0, 0, 0);
            13: return mk(2, 4, 1, 0, 0, 0, 1);
            15: return mk(0, 0, 0, 1, 0, 0, 0);
            16: return mk(2, 1, 1, 1, 0, 0, 0);
            18: return mk(5, 21, 0, 0, 0, 0, 0);
            21: return mk(4, 20, 0, 0, 0, 0, 0);
            23: return mk(6, 34, 0, 0, 0, 0, 0);
            24: return mk(3, 0, 0, 0, 1, 0, 1);
            30: return mk(0, 0, 0, 0, 1, 0, 0);
            31: return mk(1, 0, 0, 0, 0, 0, 0);
            default: return mk(7, 0, 0, 0, 0, 0, 0);
        endcase
    endfunction

    // Monitor: compare each finished run against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected run end", {26'd0, stop_addr}, 32'hFFFF_FFFF);
            end else begin
                logic [37:0] e;
                e = exp_q.pop_front();
                chk("R3 result", result, e[31:0]);
                chk("R3 stop address", {26'd0, stop_addr}, {26'd0, e[37:32]});
            end
            pops++;
        end
    end

    // Record the data level seen just before the first clock rise.
    always @(negedge clk) begin
        if (armed && pin_clk && !prev_clk) begin
            cap_dout = prev_dout;
            armed = 1'b0;
        end
        prev_clk = pin_clk;
        prev_dout = pin_data_out;
    end

    task automatic run(input logic [5:0] spc, input logic [31:0] w,
                       input logic [31:0] er, input logic [5:0] es, input bit poke);
        int tgt;
        exp_q.push_back({es, er});
        tgt = pops + 1;
        @(negedge clk);
        start = 1'b1; start_pc = spc; start_word = w;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; start_pc = 6'd0; start_word = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0;
        end
        while (pops < tgt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input string req, input bit ck, input bit dat, input bit oe, input bit cs);
        chk(req, {28'd0, pin_clk, pin_data_out, pin_data_oe, pin_cs}, {28'd0, ck, dat, oe, cs});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R3: watchdog expired, got busy=%0d expected 0", busy);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy/done", {30'd0, busy, done}, 32'd0);
        pins("R1 pins", 0, 0, 0, 1);
        chk("R1 result", result, 32'd0);
        chk("R1 stop address", {26'd0, stop_addr}, 32'd0);

        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = a[4:0]; prog_data = prog_word(a);
        end
        @(negedge clk);
        prog_we = 1'b0;

        // R4 direct pin drive
        run(6'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 6'd1, 0);
        pins("R4 set pins", 0, 1, 1, 0);
        // R5 inversion of clock and chip-select, enable from bit 3
        run(6'd2, 32'h1, 32'h1, 6'd4, 0);
        pins("R5 flip pins", 1, 0, 0, 1);
        // R6 rotate data half by 4 through loopback; R2 start while busy ignored
        din_mode = 2'd0;
        run(6'd5, 32'h0000_1234, 32'h0000_2341, 6'd6, 1);
        // R6 address half, 8 bits
        run(6'd7, 32'hA5C3_0001, 32'hC3A5_0001, 6'd8, 0);
        pins("R6 clock back at idle", 0, pin_data_out, 1, 0);
        // R6 count 0 shifts one bit
        din_mode = 2'd2; din_const = 1'b0;
        run(6'd9, 32'h0000_8001, 32'h0000_0002, 6'd10, 0);
        // R7 sampling phase, input tied to clock pin
        din_mode = 2'd1;
        early_sample = 1'b0;
        run(6'd11, 32'h0, 32'h0000_000F, 6'd12, 0);
        early_sample = 1'b1;
        run(6'd11, 32'h0, 32'h0000_0000, 6'd12, 0);
        run(6'd13, 32'h0, 32'h0000_000F, 6'd14, 0);
        chk("R6 idle high clock", {31'd0, pin_clk}, 32'd1);
        early_sample = 1'b0;
        run(6'd13, 32'h0, 32'h0000_0000, 6'd14, 0);
        // R8 output timing
        din_mode = 2'd0;
        armed = 1'b1;
        run(6'd15, 32'h0000_8000, 32'h0000_0001, 6'd17, 0);
        chk("R8 data before edge, normal", {31'd0, cap_dout}, 32'd1);
        late_drive = 1'b1;
        armed = 1'b1;
        run(6'd15, 32'h0000_8000, 32'h0000_0001, 6'd17, 0);
        chk("R8 data before edge, delayed", {31'd0, cap_dout}, 32'd0);
        late_drive = 1'b0;
        // R9 branches
        din_mode = 2'd2; din_const = 1'b1;
        run(6'd18, 32'h0, 32'h0, 6'd22, 0);
        din_const = 1'b0;
        run(6'd18, 32'h0, 32'h0, 6'd19, 0);
        run(6'd21, 32'h0, 32'h0, 6'd20, 0);
        run(6'd23, 32'h55, 32'h55, 6'd4, 0);
        // R10 falling off the end
        run(6'd30, 32'h7, 32'h7, 6'd31, 0);
        // R2 start address modulo 32
        run(6'd32, 32'h1234_5678, 32'h1234_5678, 6'd1, 0);
        // R11 reserved opcode is a no-op
        run(6'd24, 32'h9, 32'h9, 6'd25, 0);
        pins("R11 pins unchanged", 0, 1, 1, 0);

        chk("R3 scoreboard drained", exp_q.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule